// File: doc/BRIEF.md
# Touch Conversion Sequencer with Interrupt Pin

This block decides when a resistive touch controller may run a conversion, times each conversion, and keeps a 16-bit mask of results that are ready to read. The register interface supplies the requested function code, the requested precision, writes to the sense-enable bit, the host-mode bit and the flag from the last transfer header. A pen-pressure input comes from the panel comparator. Conversion results come in on a sample port and are cut down to 10 or 12 bits.

The sequencer runs every clock cycle. A conversion can start only when sensing is enabled and no conversion is running. Some functions also need the pen to be down. Unread data switches sensing off for most functions. A finished conversion ORs a function-specific mask into the data-available word. Reads clear bits from that word. One interrupt pin reports pen state, data state or both, as chosen by a 2-bit selector.

Top module: `touch_conv_seq`

## Requirements
- R1: Function codes 0 to 4 start a conversion only while `pen` is 1. Codes 5 to 11 start whatever the value of `pen`. Codes 12 to 15 never start one.
- R2: When a conversion finishes, this mask is ORed into `dav`, selected by the function that ran. Codes 0..11 give F000, C000, 8000, 4000, 3000, 0800, 0400, 0200, 0800, 0040, 0020, 0080 (hex). `dav` never gains a bit in a cycle that follows a non-busy cycle.
- R3: Sensing turns itself off in these cases. For codes 0 and 1: `host_mode` is 0 and `dav` is nonzero. For codes 2 to 4: the pen is down and `dav` is nonzero. For codes 5 to 7 and 9 to 11: `dav` is nonzero. Code 8 never turns it off, so it restarts one cycle after each finish. Once sensing is off, nothing starts until a new sense-enable write.
- R4: A start happens on the same clock edge as a sense-enable write of 1 when all the conditions hold. It sets `busy` and latches `next_func` and `next_prec`. `func_status` is zero when idle and has exactly bit `next_func` set while busy.
- R5: `busy` stays high for exactly `CONV_CYCLES` cycles. It then clears together with `func_status`, in the same edge that updates `dav`.
- R6: At each start, `pend_flag` takes the inverse of `hdr_flag`. At all other times it holds its value.
- R7: `irq` depends on `pin_sel`. With 0, it is 1 when the pen is up and `dav` is nonzero. With 1 or 3, it is 1 when `dav` is zero. With 2, it is 1 when the pen is up.
- R8: A one-cycle `rd_stb` clears bits of `dav`, chosen by `rd_reg`: 0 clears 8000, 1 clears 4000, 2 clears 2000, 3 clears 1000, 4 clears 0800, 5 clears 0400, 6 clears 2200, and 7 (status) clears 00E0.
- R9: `result` is `sample_in` shifted right by 4 when the latched precision is 1 (12-bit). It is shifted right by 6, zero-extended, when the precision is 0 (10-bit).
- R10: After reset these outputs hold: `busy` = 0, `dav` = 0, `func_status` = 0, `pend_flag` = 1. Sensing is off and the latched precision is 0.
- R11: A sense-enable write of 0 during a conversion cancels it on that edge. `busy` and `func_status` clear and `dav` is left unchanged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| next_func | input | 4 | Requested function code |
| next_prec | input | 1 | Requested precision, 1 = 12-bit |
| sense_wr | input | 1 | Write strobe for the sense-enable bit |
| sense_val | input | 1 | Value written to sense-enable |
| host_mode | input | 1 | Host-controlled scan mode |
| pen | input | 1 | Pen pressed |
| hdr_flag | input | 1 | Flag from the last transfer header |
| pin_sel | input | 2 | Interrupt pin function select |
| rd_stb | input | 1 | Result/status read pulse |
| rd_reg | input | 3 | Register index being read |
| sample_in | input | 16 | Raw conversion sample |
| busy | output | 1 | Conversion running |
| func_status | output | 16 | One-hot active function, zero when idle |
| dav | output | 16 | Data-available mask |
| pend_flag | output | 1 | Pending-status flag |
| irq | output | 1 | Interrupt pin |
| result | output | 12 | Sample cut to the latched precision |

## Verification
The assertions assume all inputs are synchronous to `clk`. They also assume `rd_stb` and `sense_wr` are single-cycle pulses, and that `hdr_flag` at the start edge is the value the pending flag must follow. The stimulus changes inputs only a short time after a rising edge. It holds every strobe for exactly one cycle and applies a full reset before each table entry. This way, leftover `dav` bits or a running conversion never carry into the next case.

// File: rtl/touch_conv_seq.sv
module touch_conv_seq #(
  parameter int CONV_CYCLES = 1000
) (
  input  logic        clk,
  input  logic        rst_n,
  input  logic [3:0]  next_func,
  input  logic        next_prec,
  input  logic        sense_wr,
  input  logic        sense_val,
  input  logic        host_mode,
  input  logic        pen,
  input  logic        hdr_flag,
  input  logic [1:0]  pin_sel,
  input  logic        rd_stb,
  input  logic [2:0]  rd_reg,
  input  logic [15:0] sample_in,
  output logic        busy,
  output logic [15:0] func_status,
  output logic [15:0] dav,
  output logic        pend_flag,
  output logic        irq,
  output logic [11:0] result
);
  localparam int CW = $clog2(CONV_CYCLES + 1);
  localparam logic [CW-1:0] LAST = CW'(CONV_CYCLES - 1);

  logic          enabled, prec_q, act_v;
  logic [3:0]    act_f;
  logic [CW-1:0] cnt;
  logic          en_w, auto_off, eligible, en_eff, start, cancel, done;
  logic [15:0]   clr_mask, set_mask;

  function automatic logic [15:0] done_mask(input logic [3:0] f);
    case (f)
      4'd0:    done_mask = 16'hF000;
      4'd1:    done_mask = 16'hC000;
      4'd2:    done_mask = 16'h8000;
      4'd3:    done_mask = 16'h4000;
      4'd4:    done_mask = 16'h3000;
      4'd5:    done_mask = 16'h0800;
      4'd6:    done_mask = 16'h0400;
      4'd7:    done_mask = 16'h0200;
      4'd8:    done_mask = 16'h0800;
      4'd9:    done_mask = 16'h0040;
      4'd10:   done_mask = 16'h0020;
      4'd11:   done_mask = 16'h0080;
      default: done_mask = 16'h0000;
    endcase
  endfunction

  always_comb begin
    auto_off = 1'b0;
    eligible = 1'b0;
    case (next_func)
      4'd0, 4'd1: begin
        auto_off = !host_mode && (|dav);
        eligible = pen;
      end
      4'd2, 4'd3, 4'd4: begin
        auto_off = pen && (|dav);
        eligible = pen;
      end
      4'd5, 4'd6, 4'd7, 4'd9, 4'd10, 4'd11: begin
        auto_off = |dav;
        eligible = 1'b1;
      end
      4'd8: eligible = 1'b1;
      default: ;
    endcase
  end

  always_comb begin
    case (rd_reg)
      3'd0: clr_mask = 16'h8000;
      3'd1: clr_mask = 16'h4000;
      3'd2: clr_mask = 16'h2000;
      3'd3: clr_mask = 16'h1000;
      3'd4: clr_mask = 16'h0800;
      3'd5: clr_mask = 16'h0400;
      3'd6: clr_mask = 16'h2200;
      default: clr_mask = 16'h00E0;
    endcase
    if (!rd_stb) clr_mask = 16'h0000;
  end

  assign en_w     = sense_wr ? sense_val : enabled;
  assign en_eff   = en_w && !auto_off;
  assign start    = eligible && en_eff && !busy;
  assign cancel   = busy && sense_wr && !sense_val;
  assign done     = busy && (cnt == LAST) && !cancel;
  assign set_mask = done ? done_mask(act_f) : 16'h0000;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      enabled   <= 1'b0;
      busy      <= 1'b0;
      act_v     <= 1'b0;
      act_f     <= 4'd0;
      prec_q    <= 1'b0;
      pend_flag <= 1'b1;
      cnt       <= '0;
      dav       <= 16'h0000;
    end else begin
      enabled <= en_eff;
      dav     <= (dav & ~clr_mask) | set_mask;
      if (start) begin
        busy      <= 1'b1;
        act_v     <= 1'b1;
        act_f     <= next_func;
        prec_q    <= next_prec;
        pend_flag <= ~hdr_flag;
        cnt       <= '0;
      end else if (cancel || done) begin
        busy  <= 1'b0;
        act_v <= 1'b0;
        cnt   <= '0;
      end else if (busy) begin
        cnt <= cnt + 1'b1;
      end
    end
  end

  assign func_status = act_v ? (16'h0001 << act_f) : 16'h0000;
  assign result      = prec_q ? sample_in[15:4] : {2'b00, sample_in[15:6]};

  always_comb begin
    case (pin_sel)
      2'd0:    irq = !pen && (|dav);
      2'd2:    irq = !pen;
      default: irq = ~|dav;
    endcase
  end
endmodule

module touch_conv_seq_chk #(
  parameter int CONV_CYCLES = 1000
) (
  input logic        clk,
  input logic        rst_n,
  input logic [3:0]  next_func,
  input logic        sense_wr,
  input logic        sense_val,
  input logic        pen,
  input logic        hdr_flag,
  input logic        busy,
  input logic [15:0] func_status,
  input logic [15:0] dav,
  input logic        pend_flag
);
  int bcnt;
  always_ff @(posedge clk) begin
    if (!rst_n) bcnt <= 0;
    else        bcnt <= busy ? bcnt + 1 : 0;
  end

  AST_FUNC_ONEHOT: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0(func_status) && (busy == (func_status != 16'h0))); // R4
  AST_NOPEN_NOSTART: assert property (@(posedge clk) disable iff (!rst_n)
    (!busy && !pen && next_func < 4'd5) |=> !busy); // R1
  AST_RESERVED_IDLE: assert property (@(posedge clk) disable iff (!rst_n)
    (!busy && next_func >= 4'd12) |=> !busy); // R1
  AST_DAV_SET_ONLY_DONE: assert property (@(posedge clk) disable iff (!rst_n)
    !busy |=> ((dav & ~$past(dav)) == 16'h0)); // R2
  AST_PEND_AT_START: assert property (@(posedge clk) disable iff (!rst_n)
    (!busy ##1 busy) |-> (pend_flag == !$past(hdr_flag))); // R6
  AST_PEND_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    busy |=> $stable(pend_flag)); // R6
  AST_BUSY_MAX: assert property (@(posedge clk) disable iff (!rst_n)
    busy |-> (bcnt < CONV_CYCLES)); // R5
  AST_CANCEL: assert property (@(posedge clk) disable iff (!rst_n)
    (busy && sense_wr && !sense_val) |=> (!busy && $stable(dav))); // R11
endmodule

bind touch_conv_seq touch_conv_seq_chk #(.CONV_CYCLES(CONV_CYCLES)) u_chk (.*);

// File: tb/sim_touch_conv_seq.sv
module sim_touch_conv_seq;
  localparam int PERIOD = 10;
  localparam int CONV   = 8;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic [3:0]  next_func = '0;
  logic        next_prec = 1'b0;
  logic        sense_wr = 1'b0, sense_val = 1'b0, host_mode = 1'b0, pen = 1'b0, hdr_flag = 1'b0;
  logic [1:0]  pin_sel = '0;
  logic        rd_stb = 1'b0;
  logic [2:0]  rd_reg = '0;
  logic [15:0] sample_in = '0;
  logic        busy, pend_flag, irq;
  logic [15:0] func_status, dav;
  logic [11:0] result;
  int checks = 0, errors = 0;

  touch_conv_seq #(.CONV_CYCLES(CONV)) u0 (.*);

  always #(PERIOD/2) clk = ~clk;

  // {code, pen, host_mode, expected dav after the run}
  localparam logic [21:0] VEC [0:20] = '{
    {4'd0, 1'b1, 1'b1, 16'hF000}, {4'd1, 1'b1, 1'b1, 16'hC000},
    {4'd2, 1'b1, 1'b1, 16'h8000}, {4'd3, 1'b1, 1'b1, 16'h4000},
    {4'd4, 1'b1, 1'b1, 16'h3000}, {4'd5, 1'b1, 1'b1, 16'h0800},
    {4'd6, 1'b1, 1'b1, 16'h0400}, {4'd7, 1'b1, 1'b1, 16'h0200},
    {4'd8, 1'b1, 1'b1, 16'h0800}, {4'd9, 1'b1, 1'b1, 16'h0040},
    {4'd10, 1'b1, 1'b1, 16'h0020}, {4'd11, 1'b1, 1'b1, 16'h0080},
    {4'd12, 1'b1, 1'b1, 16'h0000}, {4'd13, 1'b1, 1'b1, 16'h0000},
    {4'd14, 1'b1, 1'b1, 16'h0000}, {4'd15, 1'b1, 1'b1, 16'h0000},
    {4'd0, 1'b0, 1'b1, 16'h0000}, {4'd2, 1'b0, 1'b1, 16'h0000},
    {4'd4, 1'b0, 1'b1, 16'h0000}, {4'd8, 1'b0, 1'b1, 16'h0800},
    {4'd11, 1'b0, 1'b1, 16'h0080}
  };

  task automatic tick(input int n = 1);
    for (int i = 0; i < n; i++) begin
      @(posedge clk);
      #2;
    end
  endtask

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic do_reset();
    rst_n = 1'b0;
    tick(2);
    rst_n = 1'b1;
  endtask

  task automatic sense(input logic [3:0] code, input logic prec, input logic val);
    next_func = code;
    next_prec = prec;
    sense_wr = 1'b1;
    sense_val = val;
    tick();
    sense_wr = 1'b0;
  endtask

  task automatic rd(input logic [2:0] r);
    rd_reg = r;
    rd_stb = 1'b1;
    tick();
    rd_stb = 1'b0;
  endtask

  initial begin
    #(PERIOD * 100000);
    errors++;
    $display("FAIL watchdog expired");
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    tick(2);
    do_reset();
    chk("R10 busy", busy, 0);
    chk("R10 dav", dav, 0);
    chk("R10 func_status", func_status, 0);
    chk("R10 pend_flag", pend_flag, 1);
    chk("R10 result prec", result, 12'h000);

    for (int k = 0; k < 21; k++) begin
      do_reset();
      pen = VEC[k][17];
      host_mode = VEC[k][16];
      sense(VEC[k][21:18], 1'b1, 1'b1);
      tick(12);
      chk($sformatf("R1 R2 code %0d pen %0d", VEC[k][21:18], VEC[k][17]), dav, VEC[k][15:0]);
    end

    // R4 R5 R9: timing, latches, status word
    do_reset();
    pen = 1'b0; host_mode = 1'b0; hdr_flag = 1'b1; sample_in = 16'hABCD;
    sense(4'd5, 1'b1, 1'b1);
    chk("R4 busy at start", busy, 1);
    chk("R4 func_status", func_status, 16'h0020);
    chk("R6 pend after hdr 1", pend_flag, 0);
    chk("R9 12-bit result", result, 12'hABC);
    next_prec = 1'b0;
    tick(7);
    chk("R5 busy last cycle", busy, 1);
    chk("R5 dav not yet", dav, 0);
    tick();
    chk("R5 busy cleared", busy, 0);
    chk("R5 status cleared", func_status, 0);
    chk("R2 aux mask", dav, 16'h0800);
    chk("R9 precision held", result, 12'hABC);

    // R3: sensing switched off by unread data
    tick();
    rd(3'd4);
    chk("R8 aux clear", dav, 0);
    tick(4);
    chk("R3 no restart after auto-off", busy, 0);
    hdr_flag = 1'b0;
    sense(4'd5, 1'b0, 1'b1);
    chk("R3 restart after new enable", busy, 1);
    chk("R6 pend after hdr 0", pend_flag, 1);
    chk("R9 10-bit result", result, 12'h2AF);

    // R3: host mode for code 0
    do_reset();
    pen = 1'b1; host_mode = 1'b0;
    sense(4'd0, 1'b1, 1'b1);
    tick(9);
    chk("R3 host off no restart", busy, 0);
    do_reset();
    host_mode = 1'b1;
    sense(4'd0, 1'b1, 1'b1);
    tick(9);
    chk("R3 host on restart", busy, 1);

    // R8 read clears and R7 interrupt modes
    tick(10);
    chk("R2 xyz mask", dav, 16'hF000);
    rd(3'd2);
    chk("R8 z1 clear", dav, 16'hD000);
    rd(3'd0);
    chk("R8 x clear", dav, 16'h5000);
    sense(4'd0, 1'b1, 1'b0);
    chk("R11 stop", busy, 0);
    pin_sel = 2'd0; pen = 1'b1; #1;
    chk("R7 mode0 pen down", irq, 0);
    pen = 1'b0; #1;
    chk("R7 mode0 pen up data", irq, 1);
    pin_sel = 2'd1; #1;
    chk("R7 mode1 data", irq, 0);
    pin_sel = 2'd2; #1;
    chk("R7 mode2 pen up", irq, 1);
    pen = 1'b1; #1;
    chk("R7 mode2 pen down", irq, 0);
    pin_sel = 2'd3; #1;
    chk("R7 mode3 data", irq, 0);
    rd(3'd1);
    rd(3'd3);
    chk("R8 all clear", dav, 0);
    chk("R7 mode3 no data", irq, 1);
    pin_sel = 2'd0;

    // R8 status read clears test bits
    do_reset();
    sense(4'd9, 1'b1, 1'b1);
    tick(10);
    chk("R2 x test mask", dav, 16'h0040);
    rd(3'd7);
    chk("R8 status clear", dav, 0);

    // R11 cancel
    do_reset();
    sense(4'd10, 1'b1, 1'b1);
    tick(3);
    sense(4'd10, 1'b1, 1'b0);
    chk("R11 busy cancelled", busy, 0);
    chk("R11 status cancelled", func_status, 0);
    tick(12);
    chk("R11 no data", dav, 0);

    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule